// File: doc/BRIEF.md
# 16-bit Memory Operand Address Former

This block turns the addressing byte of a 16-bit instruction, plus any displacement bytes after it, into an effective offset and a default segment. Bytes arrive one per cycle on a valid-qualified input. The first accepted byte after a result (or after reset) is taken as the addressing byte. Its top two bits pick the addressing mode. Its bottom three bits pick the base/index pairing. Its middle three bits are passed through untouched for the register-operand decoder downstream.

The register values for BX, BP, SI and DI are taken from dedicated input ports. They are sampled on the edge that accepts the final byte of the operand. One cycle after that edge, a single-cycle done pulse appears. With it come the effective offset, a flag saying the default segment is the stack segment, a flag saying the operand is a register rather than memory, the pass-through register field, and the number of bytes consumed. These outputs hold their values until the next done pulse.

Top module: `ea16_unit`

## Requirements
- R1: The addressing byte is split as mode = bits 7:6, pass-through field = bits 5:3, selector = bits 2:0. On done, `out_reg` equals bits 5:3 of the addressing byte.
- R2: The selector picks the base value as follows: 0 = BX+SI, 1 = BX+DI, 2 = BP+SI, 3 = BP+DI, 4 = SI, 5 = DI, 6 = BP, 7 = BX.
- R3: Mode 00 with any selector except 6 takes no displacement. Done follows one cycle after the addressing byte, and the length is 1.
- R4: Mode 01 takes one displacement byte, sign-extended to 16 bits. Done follows one cycle after that byte, and the length is 2.
- R5: Mode 10 takes two displacement bytes, low byte first. Done follows one cycle after the high byte, and the length is 3.
- R6: Mode 00 with selector 6 is a direct address. The offset equals the 16-bit displacement (low byte first) with no register added, the segment is DS (`out_seg_ss`=0), and the length is 3.
- R7: `out_seg_ss` is 1 for selectors 2 and 3 in any memory mode, and for selector 6 in modes 01 and 10. It is 0 for every other memory form.
- R8: Mode 11 is a register operand: `out_is_reg`=1, length 1, offset 0, `out_seg_ss`=0. Done follows one cycle after the addressing byte.
- R9: The sum of base, index and displacement wraps modulo 65536.
- R10: Cycles with `in_valid` low are ignored, whatever the value of `in_byte`. Gaps between the bytes of one operand do not change the result. Outputs hold their values and no done pulse appears until the next operand completes.
- R11: After reset, `out_done` is 0 and every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | `in_byte` carries an instruction byte this cycle |
| in_byte | input | 8 | Addressing byte or displacement byte |
| bx_val | input | 16 | Current BX value |
| bp_val | input | 16 | Current BP value |
| si_val | input | 16 | Current SI value |
| di_val | input | 16 | Current DI value |
| out_done | output | 1 | One-cycle pulse: results valid |
| out_offset | output | 16 | Effective offset |
| out_seg_ss | output | 1 | 1 = default segment SS, 0 = DS |
| out_is_reg | output | 1 | Operand is a register, not memory |
| out_reg | output | 3 | Pass-through field, bits 5:3 of the addressing byte |
| out_len | output | 2 | Bytes consumed, 1 to 3 |

## Verification
Every result is due exactly one cycle after the edge that accepts the operand's last byte. That byte is the addressing byte for the no-displacement and register forms, and the final displacement byte otherwise. The driver drives bytes on falling edges. On the falling edge right after its last byte it checks that `out_done` is high. A monitor pops the expected item whenever `out_done` is seen, so a pulse that comes early, or one nobody expects, finds an empty or mismatched queue and is reported. Idle gaps inserted between bytes shift the due cycle by exactly the gap length, and the same single-cycle rule is checked after them.

// File: rtl/ea16_pkg.sv
package ea16_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;
  localparam int SEL_W  = 3;
  localparam int LEN_W  = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    MD_NONE = 2'b00,
    MD_D8   = 2'b01,
    MD_D16  = 2'b10,
    MD_REG  = 2'b11
  } mode_e;

  localparam logic [SEL_W-1:0] SEL_DIRECT = 3'b110;

  // Number of displacement bytes that follow the addressing byte
  function automatic logic [LEN_W-1:0] disp_bytes(input byte_t m);
    mode_e md;
    md = mode_e'(m[7:6]);
    case (md)
      MD_D8:   return 2'd1;
      MD_D16:  return 2'd2;
      MD_NONE: return (m[2:0] == SEL_DIRECT) ? 2'd2 : 2'd0;
      default: return 2'd0;
    endcase
  endfunction

  function automatic addr_t sext_byte(input byte_t b);
    return {{(ADDR_W-BYTE_W){b[BYTE_W-1]}}, b};
  endfunction

  // Base plus index from the fixed pairing table; the direct form has no base
  function automatic addr_t pair_sum(input logic [1:0] md, input logic [SEL_W-1:0] sel,
                                     input addr_t bx, input addr_t bp,
                                     input addr_t si, input addr_t di);
    case (sel)
      3'd0: return bx + si;
      3'd1: return bx + di;
      3'd2: return bp + si;
      3'd3: return bp + di;
      3'd4: return si;
      3'd5: return di;
      3'd6: return (md == MD_NONE) ? '0 : bp;
      default: return bx;
    endcase
  endfunction
endpackage

// File: rtl/ea16_decode.sv
module ea16_decode
  import ea16_pkg::*;
(
  input  logic [1:0]       mode,
  input  logic [SEL_W-1:0] sel,
  output logic             seg_ss,
  output logic             is_reg,
  output logic             direct
);
  always_comb begin
    is_reg = (mode == MD_REG);
    direct = (mode == MD_NONE) && (sel == SEL_DIRECT);
    seg_ss = 1'b0;
    if (!is_reg) begin
      if (sel == 3'd2 || sel == 3'd3) seg_ss = 1'b1;
      else if (sel == SEL_DIRECT && mode != MD_NONE) seg_ss = 1'b1;
    end
  end
endmodule

// File: rtl/ea16_collect.sv
module ea16_collect
  import ea16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  byte_t            in_byte,
  output logic             fin,
  output byte_t            fin_modrm,
  output addr_t            fin_disp,
  output logic [LEN_W-1:0] fin_len
);
  typedef enum logic {S_IDLE, S_DISP} st_e;

  st_e              st_q;
  byte_t            modrm_q;
  byte_t            lo_q;
  logic             have_lo_q;
  byte_t            cur_m;
  logic [LEN_W-1:0] need;
  logic             accept_byte;

  assign accept_byte = in_valid;
  assign cur_m       = (st_q == S_IDLE) ? in_byte : modrm_q;
  assign need        = disp_bytes(cur_m);
  assign fin_modrm   = cur_m;
  assign fin_len     = LEN_W'(1) + need;

  always_comb begin
    fin      = 1'b0;
    fin_disp = '0;
    if (accept_byte) begin
      if (st_q == S_IDLE) begin
        fin = (need == '0);
      end else if (need == 2'd1) begin
        fin      = 1'b1;
        fin_disp = sext_byte(in_byte);
      end else if (have_lo_q) begin
        fin      = 1'b1;
        fin_disp = {in_byte, lo_q};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      modrm_q   <= '0;
      lo_q      <= '0;
      have_lo_q <= 1'b0;
    end else if (accept_byte) begin
      if (st_q == S_IDLE) begin
        if (need != '0) begin
          st_q      <= S_DISP;
          modrm_q   <= in_byte;
          have_lo_q <= 1'b0;
        end
      end else if (fin) begin
        st_q      <= S_IDLE;
        have_lo_q <= 1'b0;
      end else begin
        lo_q      <= in_byte;
        have_lo_q <= 1'b1;
      end
    end
  end

  AST_DISP_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DISP) |-> (need != '0)); // R4
  AST_LOW_ONLY_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    have_lo_q |-> (st_q == S_DISP && need == 2'd2)); // R5
endmodule

// File: rtl/ea16_agen.sv
module ea16_agen
  import ea16_pkg::*;
(
  input  logic [1:0]       mode,
  input  logic [SEL_W-1:0] sel,
  input  addr_t            disp,
  input  addr_t            bx,
  input  addr_t            bp,
  input  addr_t            si,
  input  addr_t            di,
  output addr_t            offset
);
  always_comb begin
    if (mode == MD_REG) offset = '0;
    else                offset = pair_sum(mode, sel, bx, bp, si, di) + disp;
  end
endmodule

// File: rtl/ea16_unit.sv
module ea16_unit
  import ea16_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  input  logic [15:0] bx_val,
  input  logic [15:0] bp_val,
  input  logic [15:0] si_val,
  input  logic [15:0] di_val,
  output logic        out_done,
  output logic [15:0] out_offset,
  output logic        out_seg_ss,
  output logic        out_is_reg,
  output logic [2:0]  out_reg,
  output logic [1:0]  out_len
);
  logic             fin;
  byte_t            fin_modrm;
  addr_t            fin_disp;
  logic [LEN_W-1:0] fin_len;
  logic             dec_ss, dec_reg, dec_direct;
  addr_t            ea_next;

  ea16_collect u_collect (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .fin(fin), .fin_modrm(fin_modrm), .fin_disp(fin_disp), .fin_len(fin_len)
  );

  ea16_decode u_decode (
    .mode(fin_modrm[7:6]), .sel(fin_modrm[2:0]),
    .seg_ss(dec_ss), .is_reg(dec_reg), .direct(dec_direct)
  );

  ea16_agen u_agen (
    .mode(fin_modrm[7:6]), .sel(fin_modrm[2:0]), .disp(fin_disp),
    .bx(bx_val), .bp(bp_val), .si(si_val), .di(di_val), .offset(ea_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_done   <= 1'b0;
      out_offset <= '0;
      out_seg_ss <= 1'b0;
      out_is_reg <= 1'b0;
      out_reg    <= '0;
      out_len    <= '0;
    end else begin
      out_done <= fin;
      if (fin) begin
        out_offset <= ea_next;
        out_seg_ss <= dec_ss;
        out_is_reg <= dec_reg;
        out_reg    <= fin_modrm[5:3];
        out_len    <= fin_len;
      end
    end
  end

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> out_done); // R3
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> (!out_done && $stable(out_offset) && $stable(out_len))); // R10
  AST_LEN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (out_len >= 2'd1)); // R5
  AST_REG_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_is_reg) |-> (out_len == 2'd1 && out_offset == '0 && !out_seg_ss)); // R8
  AST_DIRECT_DS: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && dec_direct) |=> (!out_seg_ss && out_len == 2'd3)); // R6
endmodule

// File: tb/sim_ea16_unit.sv
module sim_ea16_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic [15:0] bx_val = 16'h1234, bp_val = 16'hF000, si_val = 16'h0456, di_val = 16'h8001;
  logic        out_done, out_seg_ss, out_is_reg;
  logic [15:0] out_offset;
  logic [2:0]  out_reg;
  logic [1:0]  out_len;

  int n_vec = 0;
  int n_bad = 0;

  typedef struct {
    logic [15:0] off;
    logic        ss;
    logic        isreg;
    logic [2:0]  rg;
    logic [1:0]  len;
  } exp_t;
  exp_t  q[$];
  string tq[$];

  always #5 clk = ~clk;

  ea16_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .bx_val(bx_val), .bp_val(bp_val), .si_val(si_val), .di_val(di_val),
    .out_done(out_done), .out_offset(out_offset), .out_seg_ss(out_seg_ss),
    .out_is_reg(out_is_reg), .out_reg(out_reg), .out_len(out_len)
  );

  function automatic exp_t model(input logic [7:0] m, input logic [15:0] d);
    exp_t e;
    logic [1:0] md = m[7:6];
    logic [2:0] r  = m[2:0];
    logic [15:0] base;
    e.rg = m[5:3];
    e.isreg = (md == 2'd3);
    if (e.isreg) begin
      e.off = 16'h0; e.ss = 1'b0; e.len = 2'd1;
    end else begin
      if (!r[2]) base = (r[1] ? bp_val : bx_val) + (r[0] ? di_val : si_val);
      else if (!r[1]) base = r[0] ? di_val : si_val;
      else if (r[0]) base = bx_val;
      else base = (md == 2'd0) ? 16'h0 : bp_val;
      if (md == 2'd1) begin e.off = base + {{8{d[7]}}, d[7:0]}; e.len = 2'd2; end
      else if (md == 2'd2 || r == 3'd6) begin e.off = base + d; e.len = 2'd3; end
      else begin e.off = base; e.len = 2'd1; end
      e.ss = (r == 3'd2) || (r == 3'd3) || (r == 3'd6 && md != 2'd0);
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string what, input string act, input string expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", what, act, expv);
    end
  endtask

  task automatic send(input logic [7:0] m, input logic [15:0] d, input int gap, input string tag);
    exp_t e;
    int nb;
    e = model(m, d);
    nb = int'(e.len) - 1;
    q.push_back(e);
    tq.push_back(tag);
    in_valid = 1'b1; in_byte = m;
    @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      if (gap > 0) begin
        in_valid = 1'b0; in_byte = 8'hC3;
        repeat (gap) @(negedge clk);
      end
      in_valid = 1'b1;
      in_byte = (i == 0) ? d[7:0] : d[15:8];
      @(negedge clk);
    end
    in_valid = 1'b0; in_byte = 8'h5A;
    check(out_done === 1'b1, {tag, " done timing"}, $sformatf("%b", out_done), "1");
  endtask

  // Monitor: pops an expected item for each done pulse
  always @(negedge clk) begin
    if (rst_n && out_done === 1'b1) begin
      if (q.size() == 0) begin
        check(1'b0, "R10 unexpected done", "done", "none");
      end else begin
        exp_t e;
        string t;
        e = q.pop_front();
        t = tq.pop_front();
        check(out_offset === e.off && out_seg_ss === e.ss && out_is_reg === e.isreg &&
              out_reg === e.rg && out_len === e.len, t,
              $sformatf("off=%h ss=%b reg?=%b rg=%0d len=%0d", out_offset, out_seg_ss, out_is_reg, out_reg, out_len),
              $sformatf("off=%h ss=%b reg?=%b rg=%0d len=%0d", e.off, e.ss, e.isreg, e.rg, e.len));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_done === 1'b0 && out_offset === 16'h0 && out_len === 2'd0 && out_seg_ss === 1'b0 &&
          out_is_reg === 1'b0 && out_reg === 3'd0, "R11 reset state",
          $sformatf("done=%b off=%h len=%0d", out_done, out_offset, out_len), "done=0 off=0000 len=0");

    // Every mode and selector, pass-through field varied (R1 R2 R7)
    for (int md = 0; md < 4; md++) begin
      for (int r = 0; r < 8; r++) begin
        logic [7:0] m;
        m = {md[1:0], 3'(r ^ (md * 3)), r[2:0]};
        case (md)
          0: send(m, 16'h1F80, 0, (r == 6) ? "R6 direct" : "R3 R1 R2 R7 no displacement");
          1: send(m, 16'h00A5, 0, "R4 R2 R7 byte displacement");
          2: send(m, 16'h1F80, 0, "R5 R2 R7 word displacement");
          default: send(m, 16'h0000, 0, "R8 register form");
        endcase
      end
    end

    send(8'b01_000_110, 16'h007F, 0, "R4 positive byte disp");
    send(8'b10_101_011, 16'h7FFF, 0, "R9 wrap bp+di+disp");
    send(8'b01_010_010, 16'h0080, 0, "R9 R4 negative wrap");
    send(8'b00_001_110, 16'hBEEF, 0, "R6 direct alt value");

    // Idle gaps inside operands
    send(8'b10_011_001, 16'h4321, 3, "R10 gap word disp");
    send(8'b01_110_110, 16'h00F0, 2, "R10 gap byte disp");
    send(8'b00_111_110, 16'h2468, 4, "R10 gap direct");

    // Register values change between operands
    bx_val = 16'hFFFF; si_val = 16'h0002;
    send(8'b00_000_000, 16'h0000, 0, "R9 R2 wrap bx+si");

    // Hold with garbage while idle
    @(negedge clk);
    held = out_offset;
    for (int i = 0; i < 8; i++) begin
      in_valid = 1'b0; in_byte = 8'(i * 37);
      @(negedge clk);
    end
    check(out_offset === held && out_done === 1'b0, "R10 hold while idle",
          $sformatf("off=%h done=%b", out_offset, out_done), $sformatf("off=%h done=0", held));
    check(q.size() == 0, "R10 all results seen", $sformatf("%0d", q.size()), "0");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule